// File: doc/BRIEF.md
# SRAM-Page Translation Buffer

This block is a fully associative translation buffer for a memory system where the last SRAM level is run as a tagless, paged main memory. It maps virtual pages only onto SRAM physical pages. It never returns a DRAM address. A lookup presents a virtual address. One clock later the block answers with a hit and the composed SRAM physical address, or with a one-cycle miss pulse.

On a miss, software walks its hashed page table. It then installs the translation through the refill port. When software evicts an SRAM page, it presents that page's physical address on the invalidate port, and any entry that points at the page is dropped. The page size is set at run time by a size code and applies to every entry. A flush input empties the buffer. Software is expected to flush whenever it changes the page size.

Top module: `sram_page_tlb`

## Requirements
- R1: The buffer has 64 entries, and any virtual page may occupy any entry. At most one valid entry ever matches a lookup.
- R2: A lookup presented with `lk_valid` at clock edge k is answered at edge k+1. On a hit, `rsp_hit` is 1 and `rsp_pa` holds the stored physical page bits above the page offset, with the offset bits copied from `lk_va`. A lookup sees the table as it stood before any update made at the same edge.
- R3: A lookup that matches no entry raises `rsp_miss` for exactly one cycle. It leaves every entry unchanged, so translations that were present still hit afterwards.
- R4: A refill writes into the lowest-numbered invalid entry. When all 64 entries are valid, the refill replaces one entry. That entry is picked by a free-running 6-bit LFSR with polynomial x^6+x^5+1, so exactly one older translation is lost.
- R5: A refill whose virtual page is already present overwrites that entry in place. After it, a lookup returns the new physical page.
- R6: An invalidate clears the valid entry whose physical page matches `inv_pa`, compared above the current page offset.
- R7: When a refill and an invalidate arrive in the same cycle, the invalidate is applied first. With a full table, the refill therefore takes the entry just freed, and no other entry is lost.
- R8: `flush` clears every valid bit in one cycle. A refill in the same cycle is applied after the flush and is kept.
- R9: The size code `pg_sz` selects the page size as 128 << `pg_sz` bytes for codes 0 to 5, so 0 means 128 bytes and 5 means 4096 bytes. Codes 6 and 7 act as 4096. Tag and invalidate comparisons ignore the offset bits of the selected size.
- R10: Out of reset all entries are invalid, `rsp_hit` and `rsp_miss` are 0, and the first lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pg_sz | input | 3 | Page size code, 128 << code bytes, saturating at 4096 |
| flush | input | 1 | Clear all entries |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| rsp_hit | output | 1 | Lookup hit, one cycle after request |
| rsp_miss | output | 1 | Lookup miss pulse, one cycle after request |
| rsp_pa | output | 20 | SRAM physical address on a hit, else 0 |
| rf_valid | input | 1 | Install translation |
| rf_va | input | 32 | Virtual address of the page being installed |
| rf_pa | input | 20 | SRAM physical address of the page being installed |
| inv_valid | input | 1 | Invalidate by physical page |
| inv_pa | input | 20 | SRAM physical address of the evicted page |

## Verification
The hardest states to reach from the ports are a completely full table and the moment a refill lands while every entry is valid. The stimulus installs 64 distinct pages at the smallest page size and confirms that each one hits. It then forces one more refill and counts how many of the originals survive, expecting exactly 63, because the random victim cannot be predicted from outside the block. From that full state, an invalidate and a refill are issued in the same cycle. The count of surviving pages then shows whether the freed entry was reused or another translation was lost.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   typedef enum logic [1:0] {
      PICK_SAME = 2'd0,
      PICK_FREE = 2'd1,
      PICK_RAND = 2'd2
   } pick_e;

   // Feedback masks for maximal-length Fibonacci LFSRs, bit i = stage i.
   function automatic logic [7:0] lfsr_taps(input int w);
      case (w)
         3:       return 8'b0000_0110;
         4:       return 8'b0000_1100;
         5:       return 8'b0001_0100;
         6:       return 8'b0011_0000;
         7:       return 8'b0110_0000;
         default: return 8'b1011_1000;
      endcase
   endfunction

endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr
   import tlb_pkg::*;
#(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] state
);
   localparam logic [7:0]   TAP8 = lfsr_taps(W);
   localparam logic [W-1:0] TAPS = TAP8[W-1:0];

   generate
      if (W < 3 || W > 8) begin : g_bad_width
         $error("tlb_lfsr: width %0d outside 3..8", W);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= W'(1);
      else        state <= {state[W-2:0], ^(state & TAPS)};
   end
endmodule

// File: rtl/tlb_free_pick.sv
module tlb_free_pick #(
   parameter int N = 64,
   localparam int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     valid,
   output logic             any_free,
   output logic [IDX_W-1:0] free_idx
);
   always_comb begin
      any_free = 1'b0;
      free_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!valid[i]) begin
            any_free = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
   parameter int N     = 64,
   parameter int VPN_W = 25,
   parameter int PPN_W = 13,
   localparam int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             inv_en,
   input  logic [PPN_W-1:0] inv_ppn,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [VPN_W-1:0] wr_vpn,
   input  logic [PPN_W-1:0] wr_ppn,
   input  logic [VPN_W-1:0] look_vpn,
   input  logic [VPN_W-1:0] vpn_mask,
   input  logic [PPN_W-1:0] ppn_mask,
   output logic [N-1:0]     look_hit,
   output logic [N-1:0]     wr_hit,
   output logic [N-1:0]     inv_hit,
   output logic [N-1:0]     valid,
   output logic [PPN_W-1:0] hit_ppn
);
   logic [PPN_W-1:0] sel_ppn [N];

   for (genvar i = 0; i < N; i++) begin : g_ent
      logic             v;
      logic [VPN_W-1:0] vpn;
      logic [PPN_W-1:0] ppn;
      logic             wsel;

      assign wsel = wr_en && (wr_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        v <= 1'b0;
         else if (wsel)                     v <= 1'b1;
         else if (flush || (inv_en && inv_hit[i])) v <= 1'b0;
      end

      always_ff @(posedge clk) begin
         if (wsel) begin
            vpn <= wr_vpn & vpn_mask;
            ppn <= wr_ppn & ppn_mask;
         end
      end

      assign valid[i]    = v;
      assign look_hit[i] = v && (((vpn ^ look_vpn) & vpn_mask) == '0);
      assign wr_hit[i]   = v && (((vpn ^ wr_vpn) & vpn_mask) == '0);
      assign inv_hit[i]  = v && (((ppn ^ inv_ppn) & ppn_mask) == '0);
      assign sel_ppn[i]  = look_hit[i] ? ppn : '0;
   end

   always_comb begin
      hit_ppn = '0;
      for (int i = 0; i < N; i++) hit_ppn |= sel_ppn[i];
   end
endmodule

// File: rtl/sram_page_tlb.sv
module sram_page_tlb
   import tlb_pkg::*;
#(
   parameter int N_ENT     = 64,
   parameter int VA_W      = 32,
   parameter int PA_W      = 20,
   parameter int MIN_SHIFT = 7,
   parameter int MAX_SHIFT = 12,
   parameter int SZ_W      = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [SZ_W-1:0] pg_sz,
   input  logic            flush,
   input  logic            lk_valid,
   input  logic [VA_W-1:0] lk_va,
   output logic            rsp_hit,
   output logic            rsp_miss,
   output logic [PA_W-1:0] rsp_pa,
   input  logic            rf_valid,
   input  logic [VA_W-1:0] rf_va,
   input  logic [PA_W-1:0] rf_pa,
   input  logic            inv_valid,
   input  logic [PA_W-1:0] inv_pa
);
   localparam int IDX_W = $clog2(N_ENT);
   localparam int VPN_W = VA_W - MIN_SHIFT;
   localparam int PPN_W = PA_W - MIN_SHIFT;
   localparam int SPAN  = MAX_SHIFT - MIN_SHIFT;

   generate
      if ((1 << IDX_W) != N_ENT) begin : g_bad_depth
         $error("sram_page_tlb: N_ENT must be a power of two");
      end
      if (PA_W < MAX_SHIFT || VA_W < PA_W) begin : g_bad_addr
         $error("sram_page_tlb: address widths too small for page range");
      end
      if ((1 << SZ_W) <= SPAN) begin : g_bad_sz
         $error("sram_page_tlb: SZ_W cannot encode the page range");
      end
   endgenerate

   // Effective size code, saturated at the largest page.
   logic [SZ_W-1:0]  sz_eff;
   logic [VPN_W-1:0] vpn_mask;
   logic [PPN_W-1:0] ppn_mask;
   logic [PA_W-1:0]  off_mask;

   always_comb begin
      sz_eff   = (pg_sz > SZ_W'(SPAN)) ? SZ_W'(SPAN) : pg_sz;
      vpn_mask = {VPN_W{1'b1}} << sz_eff;
      ppn_mask = {PPN_W{1'b1}} << sz_eff;
      off_mask = ~({PA_W{1'b1}} << (MIN_SHIFT + int'(sz_eff)));
   end

   logic [N_ENT-1:0] look_hit, wr_hit, inv_hit, ent_valid;
   logic [PPN_W-1:0] hit_ppn;
   logic [IDX_W-1:0] wr_idx, rnd_idx, free_idx, same_idx;
   logic             any_free, any_same;
   logic [N_ENT-1:0] post_valid, same_vec;
   pick_e            pick;

   tlb_cam #(.N(N_ENT), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_cam (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .inv_en   (inv_valid),
      .inv_ppn  (inv_pa[PA_W-1:MIN_SHIFT]),
      .wr_en    (rf_valid),
      .wr_idx   (wr_idx),
      .wr_vpn   (rf_va[VA_W-1:MIN_SHIFT]),
      .wr_ppn   (rf_pa[PA_W-1:MIN_SHIFT]),
      .look_vpn (lk_va[VA_W-1:MIN_SHIFT]),
      .vpn_mask (vpn_mask),
      .ppn_mask (ppn_mask),
      .look_hit (look_hit),
      .wr_hit   (wr_hit),
      .inv_hit  (inv_hit),
      .valid    (ent_valid),
      .hit_ppn  (hit_ppn)
   );

   tlb_lfsr #(.W(IDX_W)) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .state (rnd_idx)
   );

   // Flush, then invalidate, are applied before the refill chooses a slot.
   always_comb begin
      post_valid = flush ? '0 : (ent_valid & ~(inv_valid ? inv_hit : '0));
      same_vec   = wr_hit & post_valid;
      any_same   = |same_vec;
      same_idx   = '0;
      for (int i = 0; i < N_ENT; i++) begin
         if (same_vec[i]) same_idx |= IDX_W'(i);
      end
   end

   tlb_free_pick #(.N(N_ENT)) u_free (
      .valid    (post_valid),
      .any_free (any_free),
      .free_idx (free_idx)
   );

   always_comb begin
      if (any_same)      pick = PICK_SAME;
      else if (any_free) pick = PICK_FREE;
      else               pick = PICK_RAND;
      case (pick)
         PICK_SAME: wr_idx = same_idx;
         PICK_FREE: wr_idx = free_idx;
         default:   wr_idx = rnd_idx;
      endcase
   end

   logic            look_any;
   logic [PA_W-1:0] pa_comb;

   always_comb begin
      look_any = |look_hit;
      pa_comb  = ({hit_ppn, {MIN_SHIFT{1'b0}}} & ~off_mask) | (lk_va[PA_W-1:0] & off_mask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_hit  <= 1'b0;
         rsp_miss <= 1'b0;
         rsp_pa   <= '0;
      end else begin
         rsp_hit  <= lk_valid && look_any;
         rsp_miss <= lk_valid && !look_any;
         rsp_pa   <= (lk_valid && look_any) ? pa_comb : '0;
      end
   end
endmodule

// File: rtl/sram_page_tlb_chk.sv
module sram_page_tlb_chk #(
   parameter int N_ENT = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lk_valid,
   input logic             flush,
   input logic             rf_valid,
   input logic             inv_valid,
   input logic             rsp_hit,
   input logic             rsp_miss,
   input logic [N_ENT-1:0] hit_vec,
   input logic [N_ENT-1:0] valid_vec
);
   // R1
   single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R2
   answer_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_hit || rsp_miss) |-> $past(lk_valid));

   // R3
   hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_hit && rsp_miss));

   // R3
   miss_keeps_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && hit_vec == '0 && !rf_valid && !inv_valid && !flush)
         |=> $stable(valid_vec));

   // R8
   flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !rf_valid) |=> (valid_vec == '0));

   // R8
   flush_refill_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && rf_valid) |=> ($countones(valid_vec) == 1));
endmodule

bind sram_page_tlb sram_page_tlb_chk #(.N_ENT(N_ENT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lk_valid  (lk_valid),
   .flush     (flush),
   .rf_valid  (rf_valid),
   .inv_valid (inv_valid),
   .rsp_hit   (rsp_hit),
   .rsp_miss  (rsp_miss),
   .hit_vec   (look_hit),
   .valid_vec (ent_valid)
);

// File: tb/sim_sram_page_tlb.sv
module sim_sram_page_tlb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  pg_sz = 3'd0;
   logic        flush = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_va = '0;
   logic        rsp_hit, rsp_miss;
   logic [19:0] rsp_pa;
   logic        rf_valid = 1'b0;
   logic [31:0] rf_va = '0;
   logic [19:0] rf_pa = '0;
   logic        inv_valid = 1'b0;
   logic [19:0] inv_pa = '0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   sram_page_tlb u0 (
      .clk(clk), .rst_n(rst_n), .pg_sz(pg_sz), .flush(flush),
      .lk_valid(lk_valid), .lk_va(lk_va),
      .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_pa(rsp_pa),
      .rf_valid(rf_valid), .rf_va(rf_va), .rf_pa(rf_pa),
      .inv_valid(inv_valid), .inv_pa(inv_pa)
   );

   typedef struct packed {
      logic [1:0]  op;    // 0 refill, 1 lookup, 2 invalidate
      logic [31:0] va;
      logic [19:0] pa;
      logic        hit;
      logic [19:0] epa;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VEC [NV] = '{
      '{2'd0, 32'h0000_1000, 20'h00080, 1'b0, 20'h00000, 4'd2},  // R2 install A
      '{2'd0, 32'h0000_2000, 20'h00100, 1'b0, 20'h00000, 4'd2},  // R2 install B
      '{2'd1, 32'h0000_1044, 20'h00000, 1'b1, 20'h000C4, 4'd2},  // R2 hit A
      '{2'd1, 32'h0000_2010, 20'h00000, 1'b1, 20'h00110, 4'd2},  // R2 hit B
      '{2'd1, 32'h0000_1080, 20'h00000, 1'b0, 20'h00000, 4'd9},  // R9 next 128B page
      '{2'd0, 32'h0000_1000, 20'h00300, 1'b0, 20'h00000, 4'd5},  // R5 overwrite A
      '{2'd1, 32'h0000_107F, 20'h00000, 1'b1, 20'h0037F, 4'd5},  // R5 new page
      '{2'd2, 32'h0000_0000, 20'h00100, 1'b0, 20'h00000, 4'd6},  // R6 evict B
      '{2'd1, 32'h0000_2000, 20'h00000, 1'b0, 20'h00000, 4'd6},  // R6 B gone
      '{2'd1, 32'h0000_1000, 20'h00000, 1'b1, 20'h00300, 4'd3}   // R3 A kept
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic rf, input logic [31:0] va, input logic [19:0] pa,
                        input logic inv, input logic [19:0] ipa, input logic fl);
      @(negedge clk);
      rf_valid = rf; rf_va = va; rf_pa = pa;
      inv_valid = inv; inv_pa = ipa; flush = fl;
      @(negedge clk);
      rf_valid = 1'b0; inv_valid = 1'b0; flush = 1'b0;
   endtask

   task automatic look(input logic [31:0] va, output logic h, output logic m, output logic [19:0] p);
      @(negedge clk);
      lk_valid = 1'b1; lk_va = va;
      @(negedge clk);
      lk_valid = 1'b0;
      h = rsp_hit; m = rsp_miss; p = rsp_pa;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic h, m;
      logic [19:0] p;
      int cnt;

      // R10 reset state
      repeat (3) @(negedge clk);
      check(rsp_hit == 1'b0 && rsp_miss == 1'b0, "R10 reset outputs", {rsp_hit, rsp_miss}, 0);
      rst_n = 1'b1;
      look(32'h0000_1000, h, m, p);
      check(!h && m, "R10 first lookup misses", {h, m}, 1);
      @(negedge clk);
      check(!rsp_miss, "R3 miss pulse one cycle", rsp_miss, 0);

      // table walk at 128-byte pages
      for (int i = 0; i < NV; i++) begin
         case (VEC[i].op)
            2'd0: drive(1'b1, VEC[i].va, VEC[i].pa, 1'b0, '0, 1'b0);
            2'd2: drive(1'b0, '0, '0, 1'b1, VEC[i].pa, 1'b0);
            default: begin
               look(VEC[i].va, h, m, p);
               checks++;
               if (h !== VEC[i].hit || m !== !VEC[i].hit || p !== VEC[i].epa) begin
                  errors++;
                  $display("FAIL R%0d vec %0d actual=%b/%h expected=%b/%h",
                           VEC[i].req, i, h, p, VEC[i].hit, VEC[i].epa);
               end
            end
         endcase
      end

      // R9 large pages and saturating code
      drive(1'b0, '0, '0, 1'b0, '0, 1'b1);
      pg_sz = 3'd5;
      drive(1'b1, 32'h1234_5000, 20'h0A000, 1'b0, '0, 1'b0);
      look(32'h1234_5ABC, h, m, p);
      check(h && p == 20'h0AABC, "R9 4096B page", p, 32'h0AABC);
      pg_sz = 3'd7;
      look(32'h1234_5FFF, h, m, p);
      check(h && p == 20'h0AFFF, "R9 code 7 acts as 4096", p, 32'h0AFFF);
      drive(1'b0, '0, '0, 1'b1, 20'h0A7C0, 1'b0);
      look(32'h1234_5000, h, m, p);
      check(!h && m, "R6 R9 invalidate inside page", {h, m}, 1);

      // R8 flush with refill in the same cycle
      pg_sz = 3'd0;
      drive(1'b1, 32'h0000_4000, 20'h00400, 1'b0, '0, 1'b0);
      drive(1'b1, 32'h0000_5000, 20'h00500, 1'b0, '0, 1'b1);
      look(32'h0000_4000, h, m, p);
      check(!h, "R8 flush removed old entry", h, 0);
      look(32'h0000_5010, h, m, p);
      check(h && p == 20'h00510, "R8 refill kept after flush", p, 32'h00510);

      // R4 fill every entry
      drive(1'b0, '0, '0, 1'b0, '0, 1'b1);
      for (int i = 0; i < 64; i++)
         drive(1'b1, 32'h0040_0000 + (i << 7), 20'(i << 7), 1'b0, '0, 1'b0);
      cnt = 0;
      for (int i = 0; i < 64; i++) begin
         look(32'h0040_0000 + (i << 7) + 5, h, m, p);
         if (h && p == 20'((i << 7) + 5)) cnt++;
      end
      check(cnt == 64, "R1 R4 all 64 entries hold", cnt, 64);

      // R4 refill into a full table replaces exactly one
      drive(1'b1, 32'h0080_0000, 20'h7F000, 1'b0, '0, 1'b0);
      look(32'h0080_0000, h, m, p);
      check(h && p == 20'h7F000, "R4 new entry present", p, 32'h7F000);
      cnt = 0;
      for (int i = 0; i < 64; i++) begin
         look(32'h0040_0000 + (i << 7), h, m, p);
         if (h) cnt++;
      end
      check(cnt == 63, "R4 exactly one victim", cnt, 63);

      // R7 invalidate and refill together on a full table
      drive(1'b1, 32'h0090_0000, 20'h7E000, 1'b1, 20'h7F000, 1'b0);
      look(32'h0080_0000, h, m, p);
      check(!h, "R7 invalidated entry gone", h, 0);
      look(32'h0090_0040, h, m, p);
      check(h && p == 20'h7E040, "R7 refill installed", p, 32'h7E040);
      cnt = 0;
      for (int i = 0; i < 64; i++) begin
         look(32'h0040_0000 + (i << 7), h, m, p);
         if (h) cnt++;
      end
      check(cnt == 63, "R7 refill took freed slot", cnt, 63);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule